// File: doc/BRIEF.md
# Tearing-Effect Frame Start Trigger

This block watches the single tearing-effect line that a display panel drives and turns it into a one-cycle start pulse for a frame transfer. The panel signals both line and frame timing on that one wire. The block tells the two apart by how long each pulse lasts. A frame pulse is at least as long as a programmed frame width. A line pulse is at least as long as a programmed line width and shorter than the frame width. Anything shorter is treated as noise.

A line counter is cleared by every frame pulse and advances by one on every line pulse. Software first requests a transfer. The block then waits for the selected point in the panel's scan and fires the start pulse there. That point is either the end of the frame pulse or the end of a chosen line. With the internal mode selected, the line is ignored and the request starts the transfer directly. Each pulse type has its own active-level setting. Width settings that cannot work are flagged, and while they are flagged the block refuses to arm.

Top module: `te_sync_trigger`

## Requirements
- R1: After reset, `start_trig` and `armed` are 0.
- R2: With `trig_mode` = 0 (internal), a one-cycle `start_req` gives a one-cycle `start_trig` on the next clock edge. Activity on `te_in` never triggers in this mode, and `armed` stays 0.
- R3: `config_error` is 1 when `trig_mode` is nonzero and any of these holds: `hs_width` < 2, `hs_width` equals `vs_width`, or `vs_width` is below 4 (mode 1) or below 2 (modes 2 and 3). It is 0 whenever `trig_mode` = 0.
- R4: While `config_error` is 1, `armed` is cleared on the next edge and no trigger fires.
- R5: A pulse of width >= `vs_width` ticks is a frame pulse. A pulse of width from `hs_width` to `vs_width`-1 is a line pulse. Shorter pulses change nothing.
- R6: The line count becomes 0 at the end of each frame pulse and increases by one at the end of each line pulse.
- R7: In modes 2 and 3, an armed block fires when the count reaches `trig_line`. If `trig_line` is 0, it fires at the end of the frame pulse.
- R8: In mode 1, an armed block fires at the end of the next frame pulse, whatever `trig_line` holds.
- R9: `start_req` arms the block in modes 1 to 3. A trigger lasts one cycle and disarms the block, so later frames give no trigger until a new request.
- R10: `hs_active_high` and `vs_active_high` set the active level of line and frame pulses separately: 1 means active-high and 0 means active-low.
- R11: In modes 1 to 3, `start_trig` is high after the third rising clock edge that follows the return of `te_in` to its idle level at the end of the firing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| te_in | input | 1 | Tearing-effect line from the panel |
| trig_mode | input | 2 | 0 internal, 1 frame pulse, 2/3 line number |
| hs_width | input | CNT_W | Minimum line-pulse width in ticks |
| vs_width | input | CNT_W | Minimum frame-pulse width in ticks |
| hs_active_high | input | 1 | Line pulse active level (1 = high) |
| vs_active_high | input | 1 | Frame pulse active level (1 = high) |
| trig_line | input | LINE_W | Line number to fire at |
| start_req | input | 1 | Transfer request from software |
| start_trig | output | 1 | One-cycle frame transfer start |
| armed | output | 1 | Request pending, waiting for the scan point |
| config_error | output | 1 | Width settings unusable |

## Verification
Whole frames are generated with random line-pulse and frame-pulse widths inside the legal bands and random target lines. Each trigger is attributed to the line the panel was on, which separates correct counting from counting that is off by one. Short glitches are placed between line pulses, and some pulses sit exactly on the width boundaries, so any misclassification at the edges shifts the firing line. Frames are repeated without a new request, in internal mode, and with bad width settings; a trigger in any of these shows a failed disarm or a failed block. Both polarities are used, and the latency of every trigger is measured from the pulse end.

// File: rtl/te_sync_pkg.sv
// Package: shared mode encoding and width limits for the tearing-effect trigger.
// Assumes: trigger-mode field is two bits, zero meaning internal start.
package te_sync_pkg;

    typedef enum logic [1:0] {
        TRIG_INTERNAL  = 2'd0,
        TRIG_FRAME     = 2'd1,
        TRIG_LINE_A    = 2'd2,
        TRIG_LINE_B    = 2'd3
    } trig_mode_e;

    localparam int MIN_LINE_TICKS       = 2;
    localparam int MIN_FRAME_TICKS_M1   = 4;
    localparam int MIN_FRAME_TICKS_LINE = 2;

    // Index of each pulse meter in the meter array.
    localparam int METER_LINE  = 0;
    localparam int METER_FRAME = 1;
    localparam int NUM_METERS  = 2;

    function automatic logic uses_line_count(input logic [1:0] mode);
        return (mode == TRIG_LINE_A) || (mode == TRIG_LINE_B);
    endfunction

endpackage

// File: rtl/te_input_sync.sv
// Module: te_input_sync
// Brings the asynchronous tearing-effect line into the clock domain
// through a chain of flops. Assumes STAGES >= 2; reset value is 0 and
// the pulse meters ignore activity until they have seen the idle level.
module te_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/te_pulse_meter.sv
// Module: te_pulse_meter
// Measures runs of the active level on the synchronized line and reports,
// in the cycle the run ends, whether its length falls in this meter's band.
// FRAME_KIND = 1: band is [lo_bound, inf). FRAME_KIND = 0: [lo_bound, hi_bound).
// Assumes: run counter saturates at all-ones; a run seen before the first
// idle level after reset is not reported.
module te_pulse_meter #(
    parameter int CNT_W      = 8,
    parameter bit FRAME_KIND = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             active_high,
    input  logic [CNT_W-1:0] lo_bound,
    input  logic [CNT_W-1:0] hi_bound,
    output logic             pulse_event
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic             active;
    logic             primed;
    logic [CNT_W-1:0] run_len;
    logic             run_ended;
    logic             in_band;

    assign active    = (level == active_high);
    assign run_ended = primed && !active && (run_len != '0);

    // Count consecutive active cycles, saturating, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_len <= '0;
        else if (!active)      run_len <= '0;
        else if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
    end

    // Arm measurement once the idle level has been observed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       primed <= 1'b0;
        else if (!active) primed <= 1'b1;
    end

    generate
        if (FRAME_KIND) begin : g_frame_band
            // Frame pulses: any run at least as long as the frame width.
            assign in_band = (run_len >= lo_bound);
        end else begin : g_line_band
            // Line pulses: at least the line width, shorter than frame width.
            assign in_band = (run_len >= lo_bound) && (run_len < hi_bound);
        end
    endgenerate

    assign pulse_event = run_ended && in_band;

    // R5: a reported pulse must have been preceded by an active cycle.
    a_r5_event_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_event |-> $past(active));

    // R5: a reported pulse ends the run; the counter restarts from zero.
    a_r5_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_event |=> (run_len == '0));

endmodule

// File: rtl/te_config_check.sv
// Module: te_config_check
// Flags width settings that make line and frame pulses impossible to tell
// apart or too short to measure. Purely combinational.
// Assumes: only tearing-effect modes (nonzero) are checked.
module te_config_check
    import te_sync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       trig_mode,
    input  logic [CNT_W-1:0] hs_width,
    input  logic [CNT_W-1:0] vs_width,
    output logic             config_error
);
    int  frame_min;
    logic line_short, frame_short, same_width;

    // Derive the applicable limits and compare against them.
    always_comb begin
        frame_min   = (trig_mode == TRIG_FRAME) ? MIN_FRAME_TICKS_M1
                                                : MIN_FRAME_TICKS_LINE;
        line_short  = int'(hs_width) < MIN_LINE_TICKS;
        frame_short = int'(vs_width) < frame_min;
        same_width  = (hs_width == vs_width);
        config_error = (trig_mode != TRIG_INTERNAL) &&
                       (line_short || frame_short || same_width);
    end

endmodule

// File: rtl/te_line_trigger.sv
// Module: te_line_trigger
// Keeps the line count, the armed state and the start trigger register.
// Assumes: at most one of line_event / frame_event per cycle in normal use;
// frame_event wins if both arrive.
module te_line_trigger
    import te_sync_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trig_mode,
    input  logic [LINE_W-1:0] trig_line,
    input  logic              start_req,
    input  logic              config_error,
    input  logic              line_event,
    input  logic              frame_event,
    output logic              start_trig,
    output logic              armed
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_next;
    logic              hit;
    logic              fire;
    logic              te_mode;

    assign te_mode   = (trig_mode != TRIG_INTERNAL);
    assign line_next = (line_cnt == LINE_MAX) ? line_cnt : line_cnt + 1'b1;

    // Decide whether this cycle's pulse event is the configured scan point.
    always_comb begin
        if (trig_mode == TRIG_FRAME)
            hit = frame_event;
        else if (uses_line_count(trig_mode))
            hit = (frame_event && (trig_line == '0)) ||
                  (!frame_event && line_event && (line_next == trig_line));
        else
            hit = 1'b0;
        fire = te_mode ? (armed && hit && !config_error) : start_req;
    end

    // Line counter: cleared by frame pulses, advanced by line pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)          line_cnt <= '0;
        else if (frame_event) line_cnt <= '0;
        else if (line_event)  line_cnt <= line_next;
    end

    // Armed state: set by a request in tearing modes, cleared on fire or error.
    always_ff @(posedge clk) begin
        if (!rst_n)                       armed <= 1'b0;
        else if (!te_mode || config_error) armed <= 1'b0;
        else if (fire)                    armed <= 1'b0;
        else if (start_req)               armed <= 1'b1;
    end

    // Registered one-cycle start trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) start_trig <= 1'b0;
        else        start_trig <= fire;
    end

    // R4: an error seen this cycle leaves the block disarmed next cycle.
    a_r4_error_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> !armed);

    // R9: firing always leaves the block disarmed.
    a_r9_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        start_trig |-> !armed);

    // R2: an internal-mode request starts the transfer on the next edge.
    a_r2_internal_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_mode && start_req) |=> start_trig);

    // R6: a frame pulse returns the line count to zero.
    a_r6_frame_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        frame_event |=> (line_cnt == '0));

    // R2: internal mode never holds the armed state.
    a_r2_internal_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_mode) |=> (!armed || $past(te_mode)));

endmodule

// File: rtl/te_sync_trigger.sv
// Module: te_sync_trigger (top)
// Turns a panel tearing-effect line into a one-cycle frame start pulse.
// Line and frame pulses are separated by measured width; the trigger
// fires at the end of a frame pulse or at a programmed line.
// Assumes: configuration inputs are held stable while a request is pending.
module te_sync_trigger
    import te_sync_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic [1:0]        trig_mode,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic              hs_active_high,
    input  logic              vs_active_high,
    input  logic [LINE_W-1:0] trig_line,
    input  logic              start_req,
    output logic              start_trig,
    output logic              armed,
    output logic              config_error
);
    logic                  te_sync;
    logic [NUM_METERS-1:0] meter_event;
    logic [NUM_METERS-1:0] meter_pol;
    logic [CNT_W-1:0]      meter_lo [NUM_METERS];

    assign meter_pol[METER_LINE]  = hs_active_high;
    assign meter_pol[METER_FRAME] = vs_active_high;
    assign meter_lo[METER_LINE]   = hs_width;
    assign meter_lo[METER_FRAME]  = vs_width;

    te_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (te_in),
        .sync_out (te_sync)
    );

    genvar m;
    generate
        for (m = 0; m < NUM_METERS; m++) begin : g_meter
            te_pulse_meter #(
                .CNT_W      (CNT_W),
                .FRAME_KIND (m == METER_FRAME)
            ) u_meter (
                .clk         (clk),
                .rst_n       (rst_n),
                .level       (te_sync),
                .active_high (meter_pol[m]),
                .lo_bound    (meter_lo[m]),
                .hi_bound    (vs_width),
                .pulse_event (meter_event[m])
            );
        end
    endgenerate

    te_config_check #(.CNT_W(CNT_W)) u_check (
        .trig_mode    (trig_mode),
        .hs_width     (hs_width),
        .vs_width     (vs_width),
        .config_error (config_error)
    );

    te_line_trigger #(.LINE_W(LINE_W)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_mode    (trig_mode),
        .trig_line    (trig_line),
        .start_req    (start_req),
        .config_error (config_error),
        .line_event   (meter_event[METER_LINE]),
        .frame_event  (meter_event[METER_FRAME]),
        .start_trig   (start_trig),
        .armed        (armed)
    );

    // R5: with a shared polarity a pulse cannot be both line and frame.
    a_r5_exclusive_class: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_active_high == vs_active_high) |-> !(&meter_event));

    // R1: outputs are quiet in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!start_trig && !armed));

endmodule

// File: tb/te_sync_trigger_test.sv
module te_sync_trigger_test;
    localparam int CNT_W  = 8;
    localparam int LINE_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic te_in = 1'b0;
    logic [1:0] trig_mode = 2'd0;
    logic [CNT_W-1:0] hs_width = 8'd2;
    logic [CNT_W-1:0] vs_width = 8'd5;
    logic hs_active_high = 1'b1;
    logic vs_active_high = 1'b1;
    logic [LINE_W-1:0] trig_line = '0;
    logic start_req = 1'b0;
    logic start_trig, armed, config_error;

    te_sync_trigger uut (
        .clk(clk), .rst_n(rst_n), .te_in(te_in), .trig_mode(trig_mode),
        .hs_width(hs_width), .vs_width(vs_width),
        .hs_active_high(hs_active_high), .vs_active_high(vs_active_high),
        .trig_line(trig_line), .start_req(start_req),
        .start_trig(start_trig), .armed(armed), .config_error(config_error)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, failures = 0;
    int trig_count = 0, seen_line = -9, bline = -1;
    int fall_cyc = 0, lat_bad = 0, dbl = 0;
    bit prev_trig = 1'b0, lat_check = 1'b0, done = 1'b0;
    logic idle_lvl = 1'b0;

    // Trigger monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && start_trig) begin
            trig_count++;
            seen_line = bline;
            if (prev_trig) dbl++;
            if (lat_check && (cyc - fall_cyc != 3)) lat_bad++;
        end
        prev_trig = start_trig;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input int mode, input int hs, input int vs);
        if (mode == 0) return 1'b0;
        return (hs < 2) || (hs == vs) || (vs < ((mode == 1) ? 4 : 2));
    endfunction

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        te_in = ~idle_lvl;
        tick(w);
        te_in = idle_lvl;
        fall_cyc = cyc;
    endtask

    task automatic request();
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
    endtask

    // One frame: frame pulse, then nl line pulses, optional glitches between.
    task automatic frame(input int nl, input int hmin, input int hmax,
                         input int vmin, input int vmax, input int gmax);
        bline = -1;
        te_in = idle_lvl;
        tick(10);
        pulse(rnd(vmin, vmax));
        bline = 0;
        tick(10);
        for (int i = 1; i <= nl; i++) begin
            if (gmax > 0) begin
                pulse(rnd(1, gmax));
                tick(9);
            end
            pulse(rnd(hmin, hmax));
            bline = i;
            tick(10);
        end
    endtask

    task automatic set_cfg(input int mode, input int hs, input int vs,
                           input int line, input logic act);
        trig_mode = mode[1:0];
        hs_width = hs[CNT_W-1:0];
        vs_width = vs[CNT_W-1:0];
        trig_line = line[LINE_W-1:0];
        hs_active_high = act;
        vs_active_high = act;
        idle_lvl = ~act;
        te_in = ~act;
        tick(12);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int c0;
        int mode, hs, vs, nl, ln;
        logic act;
        void'($urandom(32'd2024));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check(start_trig == 1'b0, "R1 start_trig", start_trig, 0);
        check(armed == 1'b0, "R1 armed", armed, 0);

        // R3: configuration error decoding
        set_cfg(1, 3, 3, 0, 1'b1);
        check(config_error == exp_err(1, 3, 3), "R3 equal widths", config_error, 1);
        set_cfg(1, 2, 3, 0, 1'b1);
        check(config_error == exp_err(1, 2, 3), "R3 mode1 short frame", config_error, 1);
        set_cfg(2, 2, 3, 0, 1'b1);
        check(config_error == exp_err(2, 2, 3), "R3 mode2 frame 3 ok", config_error, 0);
        set_cfg(3, 1, 5, 0, 1'b1);
        check(config_error == exp_err(3, 1, 5), "R3 short line width", config_error, 1);
        set_cfg(0, 1, 1, 0, 1'b1);
        check(config_error == exp_err(0, 1, 1), "R3 internal mode no error", config_error, 0);

        // R4: error keeps the block disarmed, no trigger across a frame
        set_cfg(1, 2, 3, 0, 1'b1);
        c0 = trig_count;
        request();
        check(armed == 1'b0, "R4 armed under error", armed, 0);
        frame(4, 2, 2, 3, 4, 0);
        check(trig_count == c0, "R4 triggers under error", trig_count - c0, 0);

        // R2: internal mode start and ignoring te_in
        set_cfg(0, 2, 5, 3, 1'b1);
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        check(start_trig == 1'b1, "R2 internal start", start_trig, 1);
        tick(1);
        check(start_trig == 1'b0, "R2 internal one cycle", start_trig, 0);
        c0 = trig_count;
        frame(5, 2, 4, 5, 7, 1);
        check(trig_count == c0, "R2 te ignored in internal mode", trig_count - c0, 0);
        check(armed == 1'b0, "R2 never armed", armed, 0);

        lat_check = 1'b1;
        // R7 R5: boundary widths, line pulses of exactly hs and vs-1, glitch hs-1
        set_cfg(2, 3, 6, 4, 1'b1);
        c0 = trig_count;
        request();
        check(armed == 1'b1, "R9 armed by request", armed, 1);
        frame(7, 3, 3, 6, 6, 2);
        check(trig_count - c0 == 1 && seen_line == 4, "R7 R5 lower boundary line", seen_line, 4);
        c0 = trig_count;
        request();
        frame(7, 5, 5, 6, 6, 2);
        check(trig_count - c0 == 1 && seen_line == 4, "R5 upper boundary line", seen_line, 4);

        // R9: no new request, no trigger
        c0 = trig_count;
        frame(7, 3, 5, 6, 8, 0);
        check(trig_count == c0, "R9 one-shot", trig_count - c0, 0);

        // R7: line 0 fires at frame pulse end
        set_cfg(3, 2, 4, 0, 1'b1);
        c0 = trig_count;
        request();
        frame(5, 2, 3, 4, 6, 1);
        check(trig_count - c0 == 1 && seen_line == 0, "R7 line zero", seen_line, 0);

        // R8: mode 1 ignores trig_line
        set_cfg(1, 2, 6, 5, 1'b1);
        c0 = trig_count;
        request();
        frame(8, 2, 5, 6, 8, 1);
        check(trig_count - c0 == 1 && seen_line == 0, "R8 frame mode", seen_line, 0);

        // R10: active-low pulses
        set_cfg(2, 2, 5, 6, 1'b0);
        c0 = trig_count;
        request();
        frame(8, 2, 4, 5, 7, 1);
        check(trig_count - c0 == 1 && seen_line == 6, "R10 active-low", seen_line, 6);

        // R6 R7 R10: random frames
        for (int k = 0; k < 20; k++) begin
            mode = (rnd(0, 3) == 0) ? 1 : rnd(2, 3);
            hs = rnd(2, 5);
            vs = hs + rnd(2, 5);
            if (mode == 1 && vs < 4) vs = 4;
            nl = rnd(4, 10);
            ln = rnd(0, nl);
            act = logic'(rnd(0, 1));
            set_cfg(mode, hs, vs, ln, act);
            c0 = trig_count;
            request();
            frame(nl, hs, vs - 1, vs, vs + 3, (rnd(0, 1) == 1) ? hs - 1 : 0);
            check(trig_count - c0 == 1 && seen_line == ((mode == 1) ? 0 : ln),
                  "R6 R7 random frame", seen_line, (mode == 1) ? 0 : ln);
        end

        // R11 R9: latency and one-cycle width over all triggers
        check(lat_bad == 0, "R11 latency", lat_bad, 0);
        check(dbl == 0, "R9 single cycle trigger", dbl, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule